// File: doc/BRIEF.md
# Serial Adapter Control and Status Unit

This block is the host-facing register file of a single-channel asynchronous serial adapter. A processor reaches it through an enable strobe, a chip select, a one-bit register select and a read/write line. Four registers live behind that decode. Two are write-only: control and transmit data. Two are read-only: status and receive data. The block holds the control fields and presents them to the serial engine in decoded form. It builds an eight-bit status byte from its own buffer flags, from the error flags the receiver reports, and from the synchronised modem lines. It also drives an active-low interrupt request.

Bit timing and line-level conversion are handled elsewhere. The transmitter pulls bytes from the transmit data register through a take pulse. The receiver pushes completed characters, each with its parity and framing error bits, through a push pulse.

A divide code of 3 in the control register is not a clock ratio. It is a software master reset that holds the serial engine idle and clears the flags until a different divide code is written. The block leaves hardware reset in this master-reset state. The usual bring-up is a write of 0x03 followed by a write of 0x15.

Top module: `serial_adapter_regs`

## Requirements
- R1: After hardware reset the control register holds 0x03, so master reset is active. Transmit-empty is 1, every other buffer and error flag is 0, and `irq_n` is 1. With both modem inputs high, the status byte reads 0x0E.
- R2: A register access happens only in a cycle with `bus_strobe`=1 and `bus_cs`=1. Select 0 with write loads control. Select 0 with read returns status. Select 1 with write loads transmit data. Select 1 with read returns receive data. `bus_rdata` shows status when `bus_rsel`=0 and receive data when `bus_rsel`=1.
- R3: Control bits [1:0] come out on `clk_div` (0 = /1, 1 = /16, 2 = /64). Bits [4:2] are the frame code. Bits [6:5] come out on `tx_mode`. Bit 7 comes out on `rx_int_en`.
- R4: The frame code decodes as follows, giving data bits, stop bits and parity. 0 = 7, 2, even. 1 = 7, 2, odd. 2 = 7, 1, even. 3 = 7, 1, odd. 4 = 8, 2, none. 5 = 8, 1, none. 6 = 8, 1, even. 7 = 8, 1, odd.
- R5: While `clk_div` is 3, `core_reset` is 1, transmit-empty is 1, and full, overrun, parity and framing flags are 0. In this state, take, push and transmit-data writes are ignored. A control write with any other divide code releases the reset from the next cycle.
- R6: Writing 0x03 and then 0x15 leaves `clk_div`=1, `word8`=1, `stop2`=0 and `parity_en`=0.
- R7: A transmit-data write puts the byte on `tx_byte` and clears transmit-empty, so `tx_valid`=1. A `tx_take` pulse sets transmit-empty again. If the write and the take fall in the same cycle, the write wins.
- R8: An accepted push while the receive register is free stores the byte, sets receive-full, and loads the parity and framing flags from `rx_perr` and `rx_ferr`. A receive-data read clears receive-full and overrun. A push in the same cycle as that read is stored without overrun.
- R9: A push while receive-full is set and no read occurs in that cycle sets overrun. The stored byte and the parity and framing flags stay unchanged.
- R10: The status layout, bit 7 down to bit 0, is: IRQ, parity error, overrun, framing error, clear-to-send, carrier-detect, transmit-empty, receive-full.
- R11: Status bit 7 is 1 and `irq_n` is 0 exactly when `rx_int_en`=1 and receive-full or overrun is set.
- R12: Status bits 3 and 2 follow `cts_n` and `dcd_n` (1 = line inactive/high) through a two-stage synchroniser. They change after the second rising clock edge following an input change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| bus_strobe | input | 1 | Access enable strobe |
| bus_cs | input | 1 | Chip select, active high |
| bus_rsel | input | 1 | Register select |
| bus_read | input | 1 | 1 = read, 0 = write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (status or receive data) |
| irq_n | output | 1 | Interrupt request, active low |
| cts_n | input | 1 | Clear-to-send modem line, active low |
| dcd_n | input | 1 | Carrier-detect modem line, active low |
| tx_byte | output | 8 | Transmit data register contents |
| tx_valid | output | 1 | Transmit data register holds an unsent byte |
| tx_take | input | 1 | Transmitter has taken the byte |
| rx_push | input | 1 | Receiver delivers a character |
| rx_byte | input | 8 | Received character |
| rx_perr | input | 1 | Parity error of the delivered character |
| rx_ferr | input | 1 | Framing error of the delivered character |
| clk_div | output | 2 | Divide select field |
| word8 | output | 1 | 1 = eight data bits, 0 = seven |
| stop2 | output | 1 | 1 = two stop bits |
| parity_en | output | 1 | Parity bit present |
| parity_odd | output | 1 | Odd parity when parity is present |
| tx_mode | output | 2 | Transmitter control field |
| rx_int_en | output | 1 | Receive interrupt enable |
| core_reset | output | 1 | Master reset holding the serial engine idle |

## Verification
The bench builds the block with its default parameters: a two-stage modem synchroniser and a reset control value of 0x03. With these values the power-up master-reset state and the two-edge modem latency are both reachable. Random streams of control writes run against take and push pulses arriving in the same cycles. This exercises the collision orderings: write against take, read against push, and a reset write against pending traffic. Directed passes walk all eight frame codes, the bring-up sequence and an overrun.

// File: rtl/sa_pkg.sv
package sa_pkg;
    localparam int BYTE_W = 8;

    typedef struct packed {
        logic [BYTE_W-1:0] ctrl;
        logic [BYTE_W-1:0] txd;
        logic [BYTE_W-1:0] rxd;
        logic              tdre;
        logic              rdrf;
        logic              ovrn;
        logic              perr;
        logic              ferr;
    } sa_state_t;

    localparam logic [1:0] DIV_MRESET = 2'b11;
endpackage

// File: rtl/sa_sync.sv
module sa_sync #(
    parameter int               WIDTH     = 2,
    parameter int               STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] chain_d [STAGES];
    logic [WIDTH-1:0] chain_q [STAGES];

    always_comb begin
        chain_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                chain_q[i] <= RESET_VAL;
            end
        end else begin
            chain_q <= chain_d;
        end
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/sa_fmt_decode.sv
module sa_fmt_decode (
    input  logic [2:0] code,
    output logic       word8,
    output logic       stop2,
    output logic       parity_en,
    output logic       parity_odd
);
    always_comb begin
        word8      = code[2];
        stop2      = !code[1] && !(code[2] && code[0]);
        parity_en  = !(code[2] && !code[1]);
        parity_odd = code[0] && parity_en;
    end

    // R4: every seven-bit frame carries a parity bit
    always_comb begin
        if (!$isunknown(code)) begin
            assert_seven_bit_parity_R4: assert (word8 || parity_en)
                else $error("seven-bit frame decoded without parity");
        end
    end
endmodule

// File: rtl/serial_adapter_regs.sv
module serial_adapter_regs
    import sa_pkg::*;
#(
    parameter int                SYNC_STAGES = 2,
    parameter logic [BYTE_W-1:0] RESET_CTRL  = 8'h03
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_strobe,
    input  logic              bus_cs,
    input  logic              bus_rsel,
    input  logic              bus_read,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic              irq_n,
    input  logic              cts_n,
    input  logic              dcd_n,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              tx_valid,
    input  logic              tx_take,
    input  logic              rx_push,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              rx_perr,
    input  logic              rx_ferr,
    output logic [1:0]        clk_div,
    output logic              word8,
    output logic              stop2,
    output logic              parity_en,
    output logic              parity_odd,
    output logic [1:0]        tx_mode,
    output logic              rx_int_en,
    output logic              core_reset
);
    sa_state_t st_d, st_q;

    logic access, wr_ctrl, wr_tdr, rd_rdr, mr_next;
    logic [1:0] modem_s;
    logic irq_flag;
    logic [BYTE_W-1:0] status;

    assign access  = bus_strobe && bus_cs;
    assign wr_ctrl = access && !bus_rsel && !bus_read;
    assign wr_tdr  = access &&  bus_rsel && !bus_read;
    assign rd_rdr  = access &&  bus_rsel &&  bus_read;

    always_comb begin
        st_d = st_q;
        if (wr_ctrl) begin
            st_d.ctrl = bus_wdata;
        end
        mr_next = (st_d.ctrl[1:0] == DIV_MRESET);
        if (mr_next) begin
            st_d.tdre = 1'b1;
            st_d.rdrf = 1'b0;
            st_d.ovrn = 1'b0;
            st_d.perr = 1'b0;
            st_d.ferr = 1'b0;
        end else begin
            if (wr_tdr) begin
                st_d.txd  = bus_wdata;
                st_d.tdre = 1'b0;
            end else if (tx_take) begin
                st_d.tdre = 1'b1;
            end
            if (rd_rdr) begin
                st_d.rdrf = 1'b0;
                st_d.ovrn = 1'b0;
            end
            if (rx_push) begin
                if (st_d.rdrf) begin
                    st_d.ovrn = 1'b1;
                end else begin
                    st_d.rxd  = rx_byte;
                    st_d.rdrf = 1'b1;
                    st_d.perr = rx_perr;
                    st_d.ferr = rx_ferr;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ctrl: RESET_CTRL, txd: '0, rxd: '0, tdre: 1'b1,
                      rdrf: 1'b0, ovrn: 1'b0, perr: 1'b0, ferr: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    sa_sync #(
        .WIDTH    (2),
        .STAGES   (SYNC_STAGES),
        .RESET_VAL(2'b11)
    ) i_modem_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({cts_n, dcd_n}),
        .dout (modem_s)
    );

    sa_fmt_decode i_fmt (
        .code      (st_q.ctrl[4:2]),
        .word8     (word8),
        .stop2     (stop2),
        .parity_en (parity_en),
        .parity_odd(parity_odd)
    );

    assign clk_div    = st_q.ctrl[1:0];
    assign tx_mode    = st_q.ctrl[6:5];
    assign rx_int_en  = st_q.ctrl[7];
    assign core_reset = (st_q.ctrl[1:0] == DIV_MRESET);
    assign tx_byte    = st_q.txd;
    assign tx_valid   = !st_q.tdre;
    assign irq_flag   = st_q.ctrl[7] && (st_q.rdrf || st_q.ovrn);
    assign irq_n      = !irq_flag;
    assign status     = {irq_flag, st_q.perr, st_q.ovrn, st_q.ferr,
                         modem_s[1], modem_s[0], st_q.tdre, st_q.rdrf};
    assign bus_rdata  = bus_rsel ? st_q.rxd : status;

    // R5: master reset keeps buffers empty and error flags clear
    assert_mreset_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
        core_reset |-> (!tx_valid && status[6:4] == 3'b000 && !status[0]));

    // R5: a non-reset divide code releases the engine
    assert_mreset_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && bus_wdata[1:0] != DIV_MRESET) |=> !core_reset);

    // R7: a data write beats a simultaneous take
    assert_write_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_tdr && !mr_next) |=> (tx_valid && tx_byte == $past(bus_wdata)));

    // R8: a read with no push frees the receive register
    assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rdr && !rx_push) |=> (!status[0] && !status[5]));

    // R9: overrun keeps the held character
    assert_overrun_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (status[0] && rx_push && !rd_rdr && !mr_next)
        |=> (status[5] && $stable(st_q.rxd) && $stable(status[6])));

    // R11: an accepted character with interrupts enabled raises the request
    assert_irq_on_push_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && rx_int_en && !wr_ctrl && !core_reset) |=> !irq_n);
endmodule

// File: tb/test_serial_adapter_regs.sv
module test_serial_adapter_regs;
    localparam int CLK_P = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_strobe = 0, bus_cs = 0, bus_rsel = 0, bus_read = 0;
    logic [7:0] bus_wdata = 0;
    logic [7:0] bus_rdata;
    logic irq_n;
    logic cts_n = 1, dcd_n = 1;
    logic [7:0] tx_byte;
    logic tx_valid;
    logic tx_take = 0, rx_push = 0, rx_perr = 0, rx_ferr = 0;
    logic [7:0] rx_byte = 0;
    logic [1:0] clk_div, tx_mode;
    logic word8, stop2, parity_en, parity_odd, rx_int_en, core_reset;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    // bench model
    logic [7:0] m_ctrl, m_txd, m_rxd;
    logic m_tdre, m_rdrf, m_ovrn, m_pe, m_fe;
    logic [1:0] m_s1, m_s2;

    always #(CLK_P/2) clk = ~clk;

    serial_adapter_regs i_serial_adapter_regs (
        .clk(clk), .rst_n(rst_n), .bus_strobe(bus_strobe), .bus_cs(bus_cs),
        .bus_rsel(bus_rsel), .bus_read(bus_read), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_n(irq_n), .cts_n(cts_n), .dcd_n(dcd_n),
        .tx_byte(tx_byte), .tx_valid(tx_valid), .tx_take(tx_take),
        .rx_push(rx_push), .rx_byte(rx_byte), .rx_perr(rx_perr), .rx_ferr(rx_ferr),
        .clk_div(clk_div), .word8(word8), .stop2(stop2), .parity_en(parity_en),
        .parity_odd(parity_odd), .tx_mode(tx_mode), .rx_int_en(rx_int_en),
        .core_reset(core_reset)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_ctrl = 8'h03; m_txd = 0; m_rxd = 0;
        m_tdre = 1; m_rdrf = 0; m_ovrn = 0; m_pe = 0; m_fe = 0;
        m_s1 = 2'b11; m_s2 = 2'b11;
    endtask

    function automatic logic [7:0] exp_status();
        logic irq;
        irq = m_ctrl[7] && (m_rdrf || m_ovrn);
        return {irq, m_pe, m_ovrn, m_fe, m_s2[1], m_s2[0], m_tdre, m_rdrf};
    endfunction

    // expected {word8, stop2, parity_en, parity_odd} per frame code (R4 table)
    function automatic logic [3:0] exp_fmt(input logic [2:0] c);
        case (c)
            3'd0: return 4'b0110;
            3'd1: return 4'b0111;
            3'd2: return 4'b0010;
            3'd3: return 4'b0011;
            3'd4: return 4'b1100;
            3'd5: return 4'b1000;
            3'd6: return 4'b1010;
            default: return 4'b1011;
        endcase
    endfunction

    task automatic model_update();
        logic acc, wc, wt, rr, mr, full;
        acc = bus_strobe && bus_cs;
        wc = acc && !bus_rsel && !bus_read;
        wt = acc && bus_rsel && !bus_read;
        rr = acc && bus_rsel && bus_read;
        if (wc) m_ctrl = bus_wdata;
        mr = (m_ctrl[1:0] == 2'b11);
        if (mr) begin
            m_tdre = 1; m_rdrf = 0; m_ovrn = 0; m_pe = 0; m_fe = 0;
        end else begin
            if (wt) begin m_txd = bus_wdata; m_tdre = 0; end
            else if (tx_take) m_tdre = 1;
            full = m_rdrf && !rr;
            if (rr) m_ovrn = 0;
            if (rx_push && full) m_ovrn = 1;
            else if (rx_push) begin
                m_rxd = rx_byte; m_pe = rx_perr; m_fe = rx_ferr; full = 1;
            end
            m_rdrf = full;
        end
        m_s2 = m_s1;
        m_s1 = {cts_n, dcd_n};
    endtask

    task automatic idle_inputs();
        bus_strobe = 0; bus_cs = 0; bus_rsel = 0; bus_read = 0;
        tx_take = 0; rx_push = 0;
    endtask

    task automatic cycle();
        @(posedge clk);
        model_update();
        @(negedge clk);
        idle_inputs();
        #1;
    endtask

    task automatic check_all();
        chk("R10 status byte", bus_rdata, exp_status());
        chk("R11 irq_n", irq_n, !(m_ctrl[7] && (m_rdrf || m_ovrn)));
        chk("R3 control fields", {rx_int_en, tx_mode, clk_div},
            {m_ctrl[7], m_ctrl[6:5], m_ctrl[1:0]});
        chk("R4 format decode", {word8, stop2, parity_en, parity_odd}, exp_fmt(m_ctrl[4:2]));
        chk("R5 core_reset", core_reset, m_ctrl[1:0] == 2'b11);
        chk("R7 tx_valid", tx_valid, !m_tdre);
        if (!m_tdre) chk("R7 tx_byte", tx_byte, m_txd);
        bus_rsel = 1; #1;
        chk("R8 receive data", bus_rdata, m_rxd);
        bus_rsel = 0; #1;
    endtask

    task automatic acc_set(input logic rs, input logic rd, input logic [7:0] d);
        bus_strobe = 1; bus_cs = 1; bus_rsel = rs; bus_read = rd; bus_wdata = d;
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R1 reset state
        chk("R1 status after reset", bus_rdata, 8'h0E);
        chk("R1 irq_n after reset", irq_n, 1'b1);
        chk("R1 control after reset", {core_reset, clk_div}, 3'b111);
        chk("R1 tx_valid after reset", tx_valid, 1'b0);

        // R5 ignored traffic during master reset
        acc_set(1, 0, 8'h5A); rx_push = 1; rx_byte = 8'h77; cycle();
        chk("R5 tx write ignored", tx_valid, 1'b0);
        chk("R5 push ignored", bus_rdata[0], 1'b0);

        // R6 bring-up sequence
        acc_set(0, 0, 8'h03); cycle();
        acc_set(0, 0, 8'h15); cycle();
        chk("R6 divide", clk_div, 2'd1);
        chk("R6 frame", {word8, stop2, parity_en}, 3'b100);
        chk("R6 reset released", core_reset, 1'b0);
        check_all();

        // R4 all frame codes
        for (int c = 0; c < 8; c++) begin
            acc_set(0, 0, {3'b000, c[2:0], 2'b01}); cycle();
            chk("R4 frame code", {word8, stop2, parity_en, parity_odd}, exp_fmt(c[2:0]));
        end

        // R2 strobe without chip select does nothing
        bus_strobe = 1; bus_cs = 0; bus_rsel = 1; bus_read = 0; bus_wdata = 8'hC3; cycle();
        chk("R2 no access without cs", tx_valid, 1'b0);
        bus_strobe = 0; bus_cs = 1; bus_rsel = 0; bus_read = 0; bus_wdata = 8'h03; cycle();
        chk("R2 no access without strobe", core_reset, 1'b0);

        // R7 write and take in the same cycle
        acc_set(1, 0, 8'h96); tx_take = 1; cycle();
        chk("R7 write beats take", {tx_valid, tx_byte}, {1'b1, 8'h96});
        tx_take = 1; cycle();
        chk("R7 take empties", tx_valid, 1'b0);

        // R8 / R9 overrun sequence with interrupts enabled
        acc_set(0, 0, 8'h95); cycle();
        rx_push = 1; rx_byte = 8'hA5; rx_perr = 1; rx_ferr = 0; cycle();
        chk("R8 receive full", bus_rdata[0], 1'b1);
        chk("R11 irq asserted", irq_n, 1'b0);
        rx_push = 1; rx_byte = 8'h3C; rx_perr = 0; rx_ferr = 1; cycle();
        chk("R9 overrun set", bus_rdata[7:4], 4'b1110);
        check_all();
        acc_set(1, 1, 8'h00); rx_push = 1; rx_byte = 8'h44; rx_perr = 0; rx_ferr = 0; cycle();
        chk("R8 read plus push no overrun", {bus_rdata[5], bus_rdata[0]}, 2'b01);
        check_all();
        acc_set(1, 1, 8'h00); cycle();
        chk("R8 read clears full", bus_rdata[0], 1'b0);
        chk("R11 irq released", irq_n, 1'b1);

        // R12 modem synchroniser latency
        cts_n = 0; dcd_n = 0;
        @(posedge clk); model_update(); #1;
        chk("R12 one edge no change", bus_rdata[3:2], 2'b11);
        @(posedge clk); model_update(); #1;
        chk("R12 two edges change", bus_rdata[3:2], 2'b00);
        @(negedge clk); #1;

        // random mix
        for (int n = 0; n < 3000; n++) begin
            int op;
            op = $urandom_range(0, 9);
            case (op)
                0: begin
                    logic [7:0] d;
                    d = 8'($urandom);
                    if ($urandom_range(0, 3) != 0 && d[1:0] == 2'b11) d[1:0] = 2'b01;
                    acc_set(0, 0, d);
                end
                1, 2: acc_set(1, 0, 8'($urandom));
                3: acc_set(0, 1, 8'h00);
                4, 5: acc_set(1, 1, 8'h00);
                6: begin bus_strobe = 1; bus_cs = 0; bus_rsel = 1'($urandom); bus_wdata = 8'($urandom); end
                default: ;
            endcase
            tx_take = ($urandom_range(0, 3) == 0);
            rx_push = ($urandom_range(0, 2) == 0);
            rx_byte = 8'($urandom);
            rx_perr = 1'($urandom);
            rx_ferr = 1'($urandom);
            if ($urandom_range(0, 7) == 0) cts_n = ~cts_n;
            if ($urandom_range(0, 7) == 0) dcd_n = ~dcd_n;
            cycle();
            check_all();
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule